// File: doc/BRIEF.md
# Interrupt Dispatch Sequencer

This block sits beside a processor's instruction sequencer and settles, at every instruction boundary, whether the core runs its next opcode or starts an interrupt entry. It supplies the 16-bit address the entry fetches its handler pointer from. NMI and IRQ events reach it as single-cycle transition pulses. An external IRQ line is also watched for rising edges. Events are kept as transitions until the opcode's last cycle and are promoted to pending requests there, unless the lock input holds them off. That last cycle is one cycle before the boundary, which models the two-stage pipeline of the core.

At a boundary the sequencer serves at most one request. NMI comes first, then IRQ, then reset. The vector depends on the mode flag the core reports at that moment. An NMI or IRQ start shows its strobe in the cycle after the boundary. A reset start first holds for a fixed 132-clock delay, built as 22 steps of 6 clocks. After power-up a reset request is already pending. Any incoming event raises a wake output, so the core can leave its wait state.

The state machine has three states:
- `DS_RUN`: waiting for a boundary.
- `DS_RST_HOLD`: counting the reset delay.
- `DS_FIRE`: the one-cycle start strobe.

Its transitions are:
- `RUN→FIRE`: an NMI or IRQ is served.
- `RUN→RST_HOLD`: reset is served.
- `RST_HOLD→FIRE`: the delay has expired.
- `FIRE→RUN`: always.

Top module: `irq_dispatch_seq`

## Requirements
- R1: Transitions are promoted to pending only in a cycle with `op_last`=1 and `lock`=0. In any other cycle they stay held and nothing becomes pending.
- R2: A held NMI transition is consumed at a sampling cycle and becomes NMI pending. An NMI pulse that arrives in the sampling cycle itself is not consumed; it is promoted at the next sampling cycle.
- R3: A held IRQ transition is consumed at a sampling cycle. It becomes IRQ pending only if `mask_i`=0. With `mask_i`=1 it is discarded.
- R4: A 0→1 change of `ext_irq` between two consecutive clocks creates an IRQ transition. A line that stays high creates no further transition.
- R5: `wake` is 1 in exactly the cycles where `nmi_edge`, `irq_edge` or a rising `ext_irq` is present.
- R6: At a boundary (`op_bound`=1 in `DS_RUN`) with the dispatch flag set, the sequencer serves NMI first, then IRQ, then reset, and serves only one. Serving clears the dispatch flag and the served request; other requests stay pending but wait for the flag to be set again. A set in the same cycle wins over the clear.
- R7: The vector is 0xFFFA for NMI with `emu_mode`=1 and 0xFFEA with `emu_mode`=0. It is 0xFFFE for IRQ with `emu_mode`=1 and 0xFFEE with `emu_mode`=0. It is 0xFFFC for reset. `emu_mode` is taken at the boundary.
- R8: For an NMI or IRQ, `int_start` is 1 in the cycle after the boundary. For reset, it is 1 in the 133rd cycle after the boundary (a 132-clock delay). Boundaries are ignored while a start is in progress.
- R9: After `rst_n` is released, a reset request and the dispatch flag are both set. A `reset_req` pulse sets both again.
- R10: With `stop_st`=1 or `wait_st`=1 at a boundary, nothing is served and all pending state is kept.
- R11: `int_start` is never high in two consecutive cycles, and `vector` is valid while it is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_last | input | 1 | Current cycle is the last cycle of an opcode (sampling point) |
| op_bound | input | 1 | Instruction boundary: dispatch decision point |
| lock | input | 1 | Holds off sampling |
| nmi_edge | input | 1 | NMI transition pulse |
| irq_edge | input | 1 | Internal IRQ transition pulse |
| ext_irq | input | 1 | External IRQ level line |
| mask_i | input | 1 | IRQ disable flag of the core |
| emu_mode | input | 1 | 1 = emulation mode, 0 = native mode |
| reset_req | input | 1 | Request a reset entry |
| wait_st | input | 1 | Core is in its wait state |
| stop_st | input | 1 | Core is in its stop state |
| int_start | output | 1 | One-cycle interrupt-start strobe |
| vector | output | 16 | Vector address, valid with `int_start` |
| wake | output | 1 | An interrupt event arrived this cycle |

## Verification
Two functions can fall in the same cycle: sampling transitions into pending state, and serving at a boundary. The bench raises `op_last` and `op_bound` together, and pulses `nmi_edge` in the sampling cycle itself. A served request may then be re-set in the cycle it is cleared, or a fresh pulse may survive the consumption that happens beside it. A behavioural model updates its pending sets in the same order the requirements state. It judges the outcome by the strobe, the vector and the wake output on every clock.

// File: rtl/irqd_pkg.sv
package irqd_pkg;

    localparam int VEC_W = 16;

    typedef enum logic [1:0] {
        DS_RUN      = 2'd0,
        DS_RST_HOLD = 2'd1,
        DS_FIRE     = 2'd2
    } disp_state_e;

    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_NMI  = 2'd1,
        SRC_IRQ  = 2'd2,
        SRC_RST  = 2'd3
    } disp_src_e;

    localparam logic [VEC_W-1:0] VEC_NMI_EMU = 16'hFFFA;
    localparam logic [VEC_W-1:0] VEC_NMI_NAT = 16'hFFEA;
    localparam logic [VEC_W-1:0] VEC_IRQ_EMU = 16'hFFFE;
    localparam logic [VEC_W-1:0] VEC_IRQ_NAT = 16'hFFEE;
    localparam logic [VEC_W-1:0] VEC_RST     = 16'hFFFC;

    function automatic logic [VEC_W-1:0] vec_of(input disp_src_e src, input logic emu);
        logic [VEC_W-1:0] v;
        unique case (src)
            SRC_NMI:  v = emu ? VEC_NMI_EMU : VEC_NMI_NAT;
            SRC_IRQ:  v = emu ? VEC_IRQ_EMU : VEC_IRQ_NAT;
            SRC_RST:  v = VEC_RST;
            default:  v = VEC_RST;
        endcase
        return v;
    endfunction

endpackage

// File: rtl/irqd_edge_capture.sv
module irqd_edge_capture (
    input  logic clk,
    input  logic rst_n,
    input  logic nmi_edge,
    input  logic irq_edge,
    input  logic ext_irq,
    input  logic consume,
    output logic nmi_trans,
    output logic irq_trans,
    output logic wake
);

    logic ext_q;
    logic ext_rise;

    assign ext_rise = ext_irq & ~ext_q;
    assign wake     = nmi_edge | irq_edge | ext_rise;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ext_q     <= 1'b0;
            nmi_trans <= 1'b0;
            irq_trans <= 1'b0;
        end else begin
            ext_q     <= ext_irq;
            nmi_trans <= (nmi_trans & ~consume) | nmi_edge;
            irq_trans <= (irq_trans & ~consume) | irq_edge | ext_rise;
        end
    end

    AST_NMI_EDGE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_edge |=> nmi_trans); // R2

    AST_EXT_RISE_TRANS: assert property (@(posedge clk) disable iff (!rst_n)
        (ext_irq && !ext_q) |=> irq_trans); // R4

endmodule

// File: rtl/irqd_pend_latch.sv
module irqd_pend_latch (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic nmi_trans,
    input  logic irq_trans,
    input  logic mask_i,
    input  logic reset_req,
    input  logic clr_nmi,
    input  logic clr_irq,
    input  logic clr_rst,
    input  logic clr_any,
    output logic nmi_pend,
    output logic irq_pend,
    output logic rst_pend,
    output logic any_pend
);

    logic set_nmi;
    logic set_irq;

    assign set_nmi = sample_en & nmi_trans;
    assign set_irq = sample_en & irq_trans & ~mask_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nmi_pend <= 1'b0;
            irq_pend <= 1'b0;
            rst_pend <= 1'b1;
            any_pend <= 1'b1;
        end else begin
            nmi_pend <= (nmi_pend & ~clr_nmi) | set_nmi;
            irq_pend <= (irq_pend & ~clr_irq) | set_irq;
            rst_pend <= (rst_pend & ~clr_rst) | reset_req;
            any_pend <= (any_pend & ~clr_any) | set_nmi | set_irq | reset_req;
        end
    end

    AST_MASKED_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && irq_trans && mask_i && !irq_pend) |=> !irq_pend); // R3

    AST_NMI_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en && nmi_trans) |=> (nmi_pend && any_pend)); // R2

endmodule

// File: rtl/irqd_rst_timer.sv
module irqd_rst_timer #(
    parameter int RST_STEPS = 22,
    parameter int STEP_CLKS = 6
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic done
);

    localparam int DELAY = RST_STEPS * STEP_CLKS;
    localparam int CNT_W = $clog2(DELAY + 1);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DELAY - 1);

    logic [CNT_W-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (!run || done) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt <= LAST)); // R8

endmodule

// File: rtl/irq_dispatch_seq.sv
module irq_dispatch_seq
    import irqd_pkg::*;
#(
    parameter int RST_STEPS = 22,
    parameter int STEP_CLKS = 6
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_last,
    input  logic             op_bound,
    input  logic             lock,
    input  logic             nmi_edge,
    input  logic             irq_edge,
    input  logic             ext_irq,
    input  logic             mask_i,
    input  logic             emu_mode,
    input  logic             reset_req,
    input  logic             wait_st,
    input  logic             stop_st,
    output logic             int_start,
    output logic [VEC_W-1:0] vector,
    output logic             wake
);

    disp_state_e      state_q, state_d;
    disp_src_e        src;
    logic [VEC_W-1:0] vec_q;
    logic             sample_en;
    logic             nmi_trans, irq_trans;
    logic             nmi_pend, irq_pend, rst_pend, any_pend;
    logic             clr_nmi, clr_irq, clr_rst, clr_any;
    logic             serve;
    logic             rst_done;

    assign sample_en = op_last & ~lock;

    irqd_edge_capture u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .nmi_edge  (nmi_edge),
        .irq_edge  (irq_edge),
        .ext_irq   (ext_irq),
        .consume   (sample_en),
        .nmi_trans (nmi_trans),
        .irq_trans (irq_trans),
        .wake      (wake)
    );

    irqd_pend_latch u_pend (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (sample_en),
        .nmi_trans (nmi_trans),
        .irq_trans (irq_trans),
        .mask_i    (mask_i),
        .reset_req (reset_req),
        .clr_nmi   (clr_nmi),
        .clr_irq   (clr_irq),
        .clr_rst   (clr_rst),
        .clr_any   (clr_any),
        .nmi_pend  (nmi_pend),
        .irq_pend  (irq_pend),
        .rst_pend  (rst_pend),
        .any_pend  (any_pend)
    );

    irqd_rst_timer #(
        .RST_STEPS (RST_STEPS),
        .STEP_CLKS (STEP_CLKS)
    ) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q == DS_RST_HOLD),
        .done  (rst_done)
    );

    // Boundary decision and next-state logic
    assign serve = (state_q == DS_RUN) && op_bound && !stop_st && !wait_st && any_pend;

    always_comb begin
        state_d = state_q;
        src     = SRC_NONE;
        clr_nmi = 1'b0;
        clr_irq = 1'b0;
        clr_rst = 1'b0;
        clr_any = 1'b0;
        unique case (state_q)
            DS_RUN: begin
                if (serve) begin
                    clr_any = 1'b1;
                    if (nmi_pend) begin
                        src     = SRC_NMI;
                        clr_nmi = 1'b1;
                        state_d = DS_FIRE;
                    end else if (irq_pend) begin
                        src     = SRC_IRQ;
                        clr_irq = 1'b1;
                        state_d = DS_FIRE;
                    end else if (rst_pend) begin
                        src     = SRC_RST;
                        clr_rst = 1'b1;
                        state_d = DS_RST_HOLD;
                    end
                end
            end
            DS_RST_HOLD: begin
                if (rst_done) state_d = DS_FIRE;
            end
            DS_FIRE: begin
                state_d = DS_RUN;
            end
            default: begin
                state_d = DS_RUN;
            end
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= DS_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Output register and strobe
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            vec_q <= VEC_RST;
        end else if (src != SRC_NONE) begin
            vec_q <= vec_of(src, emu_mode);
        end
    end

    assign int_start = (state_q == DS_FIRE);
    assign vector    = vec_q;

    AST_LOCKED_NO_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(nmi_pend) |-> $past(op_last && !lock)); // R1

    AST_NMI_BEFORE_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (serve && nmi_pend && irq_pend) |=> (irq_pend && int_start)); // R6

    AST_RESET_VECTOR: assert property (@(posedge clk) disable iff (!rst_n)
        (int_start && $past(state_q == DS_RST_HOLD)) |-> (vector == VEC_RST)); // R7

    AST_HALT_NO_SERVE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == DS_RUN) && op_bound && (stop_st || wait_st)) |=> !int_start); // R10

    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        int_start |=> !int_start); // R11

endmodule

// File: tb/irq_dispatch_seq_bench.sv
module irq_dispatch_seq_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        op_last = 1'b0, op_bound = 1'b0, lock = 1'b0;
    logic        nmi_edge = 1'b0, irq_edge = 1'b0, ext_irq = 1'b0;
    logic        mask_i = 1'b0, emu_mode = 1'b0, reset_req = 1'b0;
    logic        wait_st = 1'b0, stop_st = 1'b0;
    logic        int_start, wake;
    logic [15:0] vector;

    always #5 clk = ~clk;

    irq_dispatch_seq u_irq_dispatch_seq (
        .clk(clk), .rst_n(rst_n), .op_last(op_last), .op_bound(op_bound),
        .lock(lock), .nmi_edge(nmi_edge), .irq_edge(irq_edge), .ext_irq(ext_irq),
        .mask_i(mask_i), .emu_mode(emu_mode), .reset_req(reset_req),
        .wait_st(wait_st), .stop_st(stop_st), .int_start(int_start),
        .vector(vector), .wake(wake)
    );

    // Behavioural reference model
    int m_nmi_tr = 0, m_irq_tr = 0, m_ext_q = 0;
    int m_nmi_p = 0, m_irq_p = 0, m_rst_p = 1, m_int_p = 1;
    int m_st = 0, m_cnt = 0;
    int m_vec = 'hFFFC;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_nmi_tr = 0; m_irq_tr = 0; m_ext_q = 0;
            m_nmi_p = 0; m_irq_p = 0; m_rst_p = 1; m_int_p = 1;
            m_st = 0; m_cnt = 0;
        end else begin
            int rise, samp, disp;
            rise = (ext_irq && m_ext_q == 0) ? 1 : 0;
            samp = (op_last && !lock) ? 1 : 0;
            disp = (m_st == 0 && op_bound && !stop_st && !wait_st && m_int_p != 0) ? 1 : 0;
            if (m_st == 0) begin
                if (disp != 0) begin
                    m_int_p = 0;
                    if (m_nmi_p != 0) begin
                        m_nmi_p = 0; m_st = 2; m_vec = emu_mode ? 'hFFFA : 'hFFEA;
                    end else if (m_irq_p != 0) begin
                        m_irq_p = 0; m_st = 2; m_vec = emu_mode ? 'hFFFE : 'hFFEE;
                    end else if (m_rst_p != 0) begin
                        m_rst_p = 0; m_st = 1; m_cnt = 0; m_vec = 'hFFFC;
                    end
                end
            end else if (m_st == 1) begin
                if (m_cnt == 131) m_st = 2;
                else m_cnt = m_cnt + 1;
            end else begin
                m_st = 0;
            end
            if (samp != 0 && m_nmi_tr != 0) begin m_nmi_p = 1; m_int_p = 1; end
            if (samp != 0 && m_irq_tr != 0 && !mask_i) begin m_irq_p = 1; m_int_p = 1; end
            if (reset_req) begin m_rst_p = 1; m_int_p = 1; end
            if (samp != 0) begin m_nmi_tr = 0; m_irq_tr = 0; end
            if (nmi_edge) m_nmi_tr = 1;
            if (irq_edge || rise != 0) m_irq_tr = 1;
            m_ext_q = ext_irq ? 1 : 0;
        end
    end

    int n_chk = 0, n_fail = 0, n_start = 0;
    int last_vec = 0;
    bit finished = 0;

    // Per-cycle comparison against the model
    always @(negedge clk) begin
        if (!finished) begin
            logic e_start, e_wake;
            e_start = (m_st == 2);
            e_wake  = nmi_edge | irq_edge | (ext_irq & (m_ext_q == 0));
            n_chk++;
            if (int_start !== e_start) begin
                n_fail++;
                $display("FAIL R8 int_start act=%0b exp=%0b", int_start, e_start);
            end else if (e_start && vector !== m_vec[15:0]) begin
                n_fail++;
                $display("FAIL R7 vector act=%h exp=%h", vector, m_vec[15:0]);
            end
            if (wake !== e_wake) begin
                n_fail++;
                $display("FAIL R5 wake act=%0b exp=%0b", wake, e_wake);
            end
            if (int_start === 1'b1) begin
                n_start++;
                last_vec = vector;
            end
        end
    end

    task automatic tick();
        @(negedge clk);
        #2;
    endtask

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic pulse_tr(input bit n, input bit i);
        nmi_edge = n; irq_edge = i; tick();
        nmi_edge = 0; irq_edge = 0;
    endtask

    task automatic sample();
        op_last = 1; tick(); op_last = 0;
    endtask

    task automatic bound();
        op_bound = 1; tick(); op_bound = 0; tick();
    endtask

    task automatic finish_run();
        finished = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog act=hung exp=done");
        finish_run();
    end

    initial begin
        int s0;
        repeat (3) tick();
        chk(int_start == 1'b0, "R9 reset state strobe", int_start, 0);
        rst_n = 1; tick();

        // R9/R8: pending power-up reset served after the fixed delay
        s0 = n_start; bound();
        repeat (130) tick();
        chk(n_start == s0, "R8 reset not before delay", n_start, s0);
        repeat (5) tick();
        chk(n_start == s0 + 1, "R9 power-up reset served", n_start, s0 + 1);
        chk(last_vec == 'hFFFC, "R7 reset vector", last_vec, 'hFFFC);

        // R7: NMI in both modes
        emu_mode = 1; pulse_tr(1, 0); sample(); s0 = n_start; bound();
        chk(n_start == s0 + 1 && last_vec == 'hFFFA, "R7 NMI emu", last_vec, 'hFFFA);
        emu_mode = 0; pulse_tr(1, 0); sample(); bound();
        chk(last_vec == 'hFFEA, "R7 NMI native", last_vec, 'hFFEA);

        // R3/R7: unmasked IRQ in both modes
        pulse_tr(0, 1); sample(); bound();
        chk(last_vec == 'hFFEE, "R7 IRQ native", last_vec, 'hFFEE);
        emu_mode = 1; pulse_tr(0, 1); sample(); bound();
        chk(last_vec == 'hFFFE, "R7 IRQ emu", last_vec, 'hFFFE);
        emu_mode = 0;

        // R3: masked IRQ discarded
        mask_i = 1; pulse_tr(0, 1); sample(); s0 = n_start; bound();
        mask_i = 0; sample(); bound();
        chk(n_start == s0, "R3 masked IRQ dropped", n_start, s0);

        // R4: external line rise, then steady high
        ext_irq = 1; tick(); sample(); s0 = n_start; bound();
        chk(n_start == s0 + 1 && last_vec == 'hFFEE, "R4 ext rise", last_vec, 'hFFEE);
        sample(); bound();
        chk(n_start == s0 + 1, "R4 steady line", n_start, s0 + 1);
        ext_irq = 0; tick();

        // R1: lock holds off sampling
        pulse_tr(1, 0); lock = 1; sample(); lock = 0; s0 = n_start; bound();
        chk(n_start == s0, "R1 locked sample", n_start, s0);
        sample(); bound();
        chk(n_start == s0 + 1, "R1 unlocked sample", n_start, s0 + 1);

        // R6: NMI before IRQ, IRQ waits for a new flag set
        pulse_tr(1, 1); sample(); s0 = n_start; bound();
        chk(last_vec == 'hFFEA, "R6 NMI first", last_vec, 'hFFEA);
        bound();
        chk(n_start == s0 + 1, "R6 one per boundary", n_start, s0 + 1);
        pulse_tr(0, 1); sample(); bound();
        chk(last_vec == 'hFFEE, "R6 IRQ later", last_vec, 'hFFEE);

        // R2: pulse in sampling cycle is kept; sample and boundary together
        nmi_edge = 1; op_last = 1; tick(); nmi_edge = 0; op_last = 0;
        s0 = n_start; bound();
        chk(n_start == s0, "R2 same-cycle pulse kept", n_start, s0);
        op_last = 1; op_bound = 1; tick(); op_last = 0; op_bound = 0; tick();
        chk(n_start == s0, "R2 sample with boundary", n_start, s0);
        bound();
        chk(n_start == s0 + 1, "R2 promoted later", n_start, s0 + 1);

        // R10: stop and wait block dispatch
        pulse_tr(1, 0); sample(); s0 = n_start;
        stop_st = 1; bound(); stop_st = 0;
        wait_st = 1; bound(); wait_st = 0;
        chk(n_start == s0, "R10 halted", n_start, s0);
        bound();
        chk(n_start == s0 + 1, "R10 resumed", n_start, s0 + 1);

        // R9/R8: requested reset, boundaries during hold ignored
        reset_req = 1; tick(); reset_req = 0; s0 = n_start; bound();
        repeat (40) tick(); bound();
        repeat (100) tick();
        chk(n_start == s0 + 1 && last_vec == 'hFFFC, "R9 requested reset", last_vec, 'hFFFC);

        // R11 covered each cycle by the model compare; R5 wake likewise
        repeat (5) tick();
        finish_run();
    end

endmodule